// File: doc/BRIEF.md
# FIFO Status and Error Flag Unit

This block watches the two word queues of a serial port controller: the receive queue that the shifter fills and software drains, and the transmit queue that software fills and the shifter drains. From the push and pop strobes and the occupancy levels that the data path reports, it builds a status word. The word holds the full and not-empty indications, service requests that fire when a queue crosses its threshold, and done flags that fire when the programmed number of words has moved. A set of sticky error flags records queue overruns, queue underruns and serial clock faults. A single level interrupt stays high while any flag is pending.

Software programs the block through a simple write port. It writes a per-direction counting mode, the word count for each direction, the error enables, and write-one-to-clear masks for the three flag words. Two pairs of count registers exist. One pair serves when a direction runs in plain queue mode. The other pair serves when that direction runs in block mode or one of the DMA modes. The mode field picks which register of each pair sets the target. The queue storage and the shifter are outside this block.

Top module: `fifo_flag_ctrl`

## Requirements
- R1: The status word shows bit 7 = receive queue full (level equals DEPTH), bit 6 = transmit queue full, bit 5 = receive queue not empty, bit 4 = transmit queue not empty. These bits follow the level inputs in the same cycle.
- R2: When the receive mode field (write data bits 13:12 to the mode select) is 0, the receive target is the receive-queue count register (select 1). When the transmit mode field (bits 11:10) is 0, the transmit target is the transmit-queue count register (select 2).
- R3: When a mode field is nonzero, that direction takes its target from the block count register (select 3 for receive, select 4 for transmit) and ignores the queue-mode register.
- R4: Status bit 11 sets on the receive push that brings the receive tally to a nonzero target. Bit 10 does the same for transmit pops. Writing either count register of a direction restarts that direction's tally at zero. A zero target never sets a done flag.
- R5: Status bit 9 sets on a receive push made while the receive level is IN_THR-1. Status bit 8 sets on a transmit pop made while the transmit level is OUT_THR+1.
- R6: The error word sets bit 2 on a receive push while the receive queue is full, and bit 4 on a receive pop while it is empty. It sets bit 5 on a transmit push while the transmit queue is full. It sets bit 3 on a shift request while the transmit queue is empty and the transmit tally is below its target.
- R7: The serial error word sets bit 1 on a clock-overrun pulse and bit 0 on a clock-underrun pulse.
- R8: An error or serial error flag sets only if the enable bit at the same position is 1 (error enable select 5, serial enable select 6). With the enable bit at 0, the event leaves the flag at 0.
- R9: A write to a clear select clears exactly the flag bits whose data bits are 1: select 7 for the status flags (bits 11:8), select 8 for the error word, select 9 for the serial word. A set event in the same cycle wins over the clear.
- R10: irq is high exactly while any status flag (bits 11:8), error flag or serial error flag is set.
- R11: After reset all flags, enables, counts and modes are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select (0 mode, 1..4 counts, 5..6 enables, 7..9 clears) |
| wr_data | input | 16 | Write data |
| in_push | input | 1 | Shifter writes a word into the receive queue |
| in_pop | input | 1 | Software reads a word from the receive queue |
| in_level | input | LVL_W | Receive queue occupancy |
| out_push | input | 1 | Software writes a word into the transmit queue |
| out_pop | input | 1 | Shifter takes a word from the transmit queue |
| out_shift_req | input | 1 | Shifter needs a transmit word this cycle |
| out_level | input | LVL_W | Transmit queue occupancy |
| ser_clk_over | input | 1 | Serial clock overrun event |
| ser_clk_under | input | 1 | Serial clock underrun event |
| op_status | output | 16 | Status word (bits 11:4 used) |
| err_flags | output | 16 | Queue error word (bits 5:2 used) |
| ser_flags | output | 16 | Serial error word (bits 1:0 used) |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the choice of count register. It programs the unused register of a pair with a different count, so a unit that read the wrong one would raise done at the wrong word or never. It tests a transmit underrun with no words left, which a unit that ignored the tally would flag wrongly. It also tests an error event with its enable off, which a unit that gated only the interrupt would still record. It clears a single bit of a multi-bit error word and makes a set and a clear collide in one cycle. A loose clear mask would drop neighbouring flags, and a clear-priority register would lose the event.

// File: rtl/fflag_pkg.sv
package fflag_pkg;
  localparam int REG_W = 16;

  typedef enum logic [3:0] {
    SEL_MODES   = 4'd0,
    SEL_RX_QCNT = 4'd1,
    SEL_TX_QCNT = 4'd2,
    SEL_RX_BCNT = 4'd3,
    SEL_TX_BCNT = 4'd4,
    SEL_ERR_EN  = 4'd5,
    SEL_SER_EN  = 4'd6,
    SEL_OP_CLR  = 4'd7,
    SEL_ERR_CLR = 4'd8,
    SEL_SER_CLR = 4'd9
  } reg_sel_e;

  localparam logic [1:0] MODE_QUEUE = 2'd0;
endpackage

// File: rtl/fflag_w1c_bank.sv
module fflag_w1c_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q, flags_d;
  logic         upd;

  always_comb begin
    upd     = |set_i || |clr_i;
    flags_d = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fflag_tally.sv
module fflag_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             done_set_o,
  output logic             remain_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  always_comb begin
    cnt_inc    = cnt_q + CNT_W'(1);
    cnt_en     = restart_i || step_i;
    cnt_d      = restart_i ? '0 : cnt_inc;
    done_set_o = step_i && !restart_i && (target_i != '0) && (cnt_inc == target_i);
    remain_o   = cnt_q < target_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
  import fflag_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int IN_THR  = 8,
  parameter int OUT_THR = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             in_push,
  input  logic             in_pop,
  input  logic [LVL_W-1:0] in_level,
  input  logic             out_push,
  input  logic             out_pop,
  input  logic             out_shift_req,
  input  logic [LVL_W-1:0] out_level,
  input  logic             ser_clk_over,
  input  logic             ser_clk_under,
  output logic [REG_W-1:0] op_status,
  output logic [REG_W-1:0] err_flags,
  output logic [REG_W-1:0] ser_flags,
  output logic             irq
);
  reg_sel_e         sel;
  logic [1:0]       rx_mode_q, rx_mode_d, tx_mode_q, tx_mode_d;
  logic [REG_W-1:0] rx_qcnt_q, rx_qcnt_d, tx_qcnt_q, tx_qcnt_d;
  logic [REG_W-1:0] rx_bcnt_q, rx_bcnt_d, tx_bcnt_q, tx_bcnt_d;
  logic [3:0]       err_en_q, err_en_d;
  logic [1:0]       ser_en_q, ser_en_d;
  logic             cfg_en;

  logic [REG_W-1:0] rx_target, tx_target;
  logic             rx_restart, tx_restart;
  logic             rx_done_set, tx_done_set, rx_remain, tx_remain;
  logic             rx_full, tx_full, rx_empty, tx_empty;
  logic [3:0]       op_set, op_clr, op_q;
  logic [3:0]       err_set, err_raw, err_clr, err_q;
  logic [1:0]       ser_set, ser_clr, ser_q;

  assign sel = reg_sel_e'(wr_sel);

  // configuration next state
  always_comb begin
    rx_mode_d = rx_mode_q;  tx_mode_d = tx_mode_q;
    rx_qcnt_d = rx_qcnt_q;  tx_qcnt_d = tx_qcnt_q;
    rx_bcnt_d = rx_bcnt_q;  tx_bcnt_d = tx_bcnt_q;
    err_en_d  = err_en_q;   ser_en_d  = ser_en_q;
    cfg_en    = wr_en && (wr_sel <= 4'd6);
    if (wr_en) begin
      case (sel)
        SEL_MODES:   begin rx_mode_d = wr_data[13:12]; tx_mode_d = wr_data[11:10]; end
        SEL_RX_QCNT: rx_qcnt_d = wr_data;
        SEL_TX_QCNT: tx_qcnt_d = wr_data;
        SEL_RX_BCNT: rx_bcnt_d = wr_data;
        SEL_TX_BCNT: tx_bcnt_d = wr_data;
        SEL_ERR_EN:  err_en_d  = wr_data[5:2];
        SEL_SER_EN:  ser_en_d  = wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mode_q <= '0; tx_mode_q <= '0;
      rx_qcnt_q <= '0; tx_qcnt_q <= '0;
      rx_bcnt_q <= '0; tx_bcnt_q <= '0;
      err_en_q  <= '0; ser_en_q  <= '0;
    end else if (cfg_en) begin
      rx_mode_q <= rx_mode_d; tx_mode_q <= tx_mode_d;
      rx_qcnt_q <= rx_qcnt_d; tx_qcnt_q <= tx_qcnt_d;
      rx_bcnt_q <= rx_bcnt_d; tx_bcnt_q <= tx_bcnt_d;
      err_en_q  <= err_en_d;  ser_en_q  <= ser_en_d;
    end
  end

  // target selection and tally restart
  always_comb begin
    rx_target  = (rx_mode_q == MODE_QUEUE) ? rx_qcnt_q : rx_bcnt_q;
    tx_target  = (tx_mode_q == MODE_QUEUE) ? tx_qcnt_q : tx_bcnt_q;
    rx_restart = wr_en && (sel == SEL_RX_QCNT || sel == SEL_RX_BCNT);
    tx_restart = wr_en && (sel == SEL_TX_QCNT || sel == SEL_TX_BCNT);
  end

  fflag_tally #(.CNT_W(REG_W)) u_rx_tally (
    .clk(clk), .rst_n(rst_n), .restart_i(rx_restart), .step_i(in_push),
    .target_i(rx_target), .done_set_o(rx_done_set), .remain_o(rx_remain)
  );

  fflag_tally #(.CNT_W(REG_W)) u_tx_tally (
    .clk(clk), .rst_n(rst_n), .restart_i(tx_restart), .step_i(out_pop),
    .target_i(tx_target), .done_set_o(tx_done_set), .remain_o(tx_remain)
  );

  // event detection
  always_comb begin
    rx_full  = in_level  == LVL_W'(DEPTH);
    tx_full  = out_level == LVL_W'(DEPTH);
    rx_empty = in_level  == '0;
    tx_empty = out_level == '0;
    // order {rx done, tx done, rx service, tx service} = status bits 11:8
    op_set   = {rx_done_set, tx_done_set,
                in_push && (in_level == LVL_W'(IN_THR - 1)),
                out_pop && (out_level == LVL_W'(OUT_THR + 1))};
    // order {tx overrun, rx underrun, tx underrun, rx overrun} = error bits 5:2
    err_raw  = {out_push && tx_full, in_pop && rx_empty,
                out_shift_req && tx_empty && tx_remain, in_push && rx_full};
    err_set  = err_raw & err_en_q;
    ser_set  = {ser_clk_over, ser_clk_under} & ser_en_q;
    op_clr   = (wr_en && sel == SEL_OP_CLR)  ? wr_data[11:8] : '0;
    err_clr  = (wr_en && sel == SEL_ERR_CLR) ? wr_data[5:2]  : '0;
    ser_clr  = (wr_en && sel == SEL_SER_CLR) ? wr_data[1:0]  : '0;
  end

  fflag_w1c_bank #(.W(4)) u_op_bank (
    .clk(clk), .rst_n(rst_n), .set_i(op_set), .clr_i(op_clr), .flags_o(op_q)
  );

  fflag_w1c_bank #(.W(4)) u_err_bank (
    .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .flags_o(err_q)
  );

  fflag_w1c_bank #(.W(2)) u_ser_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ser_set), .clr_i(ser_clr), .flags_o(ser_q)
  );

  always_comb begin
    op_status = {4'b0, op_q, rx_full, tx_full, !rx_empty, !tx_empty, 4'b0};
    err_flags = {10'b0, err_q, 2'b0};
    ser_flags = {14'b0, ser_q};
    irq       = |op_q || |err_q || |ser_q;
  end
endmodule

// File: rtl/fflag_chk.sv
module fflag_chk
  import fflag_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             in_push,
  input logic [REG_W-1:0] op_status,
  input logic [REG_W-1:0] err_flags,
  input logic [REG_W-1:0] ser_flags,
  input logic             irq,
  input logic [3:0]       err_en
);
  // R1
  full_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_status[7] |-> op_status[5]);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[2] && !(wr_en && wr_sel == SEL_ERR_CLR && wr_data[2])) |=> err_flags[2]);

  // R8
  err_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[2]) |-> $past(err_en[0]));

  // R6
  rx_ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[2]) |-> $past(in_push));

  // R4
  rx_done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_status[11]) |-> $past(in_push));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_status[11:8] == '0 && err_flags == '0 && ser_flags == '0) |-> !irq);
endmodule

bind fifo_flag_ctrl fflag_chk u_fflag_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .in_push(in_push), .op_status(op_status), .err_flags(err_flags),
  .ser_flags(ser_flags), .irq(irq), .err_en(err_en_q)
);

// File: tb/fifo_flag_ctrl_bench.sv
module fifo_flag_ctrl_bench;
  localparam int DEPTH = 16;
  localparam int LVL_W = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        in_push = 0, in_pop = 0, out_push = 0, out_pop = 0, out_shift_req = 0;
  logic        ser_clk_over = 0, ser_clk_under = 0;
  logic [LVL_W-1:0] in_level = '0, out_level = '0;
  logic [15:0] op_status, err_flags, ser_flags;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  fifo_flag_ctrl #(.DEPTH(DEPTH), .IN_THR(8), .OUT_THR(4)) u_fifo_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_push(in_push), .in_pop(in_pop), .in_level(in_level),
    .out_push(out_push), .out_pop(out_pop), .out_shift_req(out_shift_req),
    .out_level(out_level), .ser_clk_over(ser_clk_over), .ser_clk_under(ser_clk_under),
    .op_status(op_status), .err_flags(err_flags), .ser_flags(ser_flags), .irq(irq)
  );

  // {in_level, out_level, expected status bits 7:4}
  localparam logic [13:0] VEC [6] = '{
    {5'd0,  5'd0,  4'b0000},
    {5'd1,  5'd0,  4'b0010},
    {5'd0,  5'd3,  4'b0001},
    {5'd16, 5'd0,  4'b1010},
    {5'd0,  5'd16, 4'b0101},
    {5'd16, 5'd16, 4'b1111}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; in_push = 0; in_pop = 0; out_push = 0; out_pop = 0;
    out_shift_req = 0; ser_clk_over = 0; ser_clk_under = 0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d; step();
  endtask

  task automatic push_in(input int lvl);
    @(negedge clk); in_level = LVL_W'(lvl); in_push = 1; step();
  endtask

  task automatic pop_out(input int lvl);
    @(negedge clk); out_level = LVL_W'(lvl); out_pop = 1; step();
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #35; rst_n = 1; #1;
    // R11 reset state
    chk("R11 status", op_status, 16'h0000);
    chk("R11 err", err_flags, 16'h0000);
    chk("R11 irq", {15'b0, irq}, 16'h0000);

    // R1 table walk
    foreach (VEC[i]) begin
      @(negedge clk);
      in_level = VEC[i][13:9]; out_level = VEC[i][8:4];
      #1 chk("R1 queue bits", {12'b0, op_status[7:4]}, {12'b0, VEC[i][3:0]});
    end
    @(negedge clk); in_level = 0; out_level = 0;

    // R2 queue mode receive target
    wr(4'd0, 16'h0000); wr(4'd3, 16'd9); wr(4'd1, 16'd3);
    push_in(0); push_in(0);
    chk("R2 rx not yet done", op_status & 16'h0800, 16'h0000);
    push_in(0);
    chk("R2 rx done", op_status & 16'h0800, 16'h0800);
    chk("R10 irq high", {15'b0, irq}, 16'h0001);
    wr(4'd7, 16'h0800);
    chk("R9 op clear", op_status & 16'h0F00, 16'h0000);
    chk("R10 irq low", {15'b0, irq}, 16'h0000);
    // R4 zero target
    wr(4'd1, 16'd0); push_in(0);
    chk("R4 zero target", op_status & 16'h0F00, 16'h0000);

    // R3 block mode
    wr(4'd0, 16'h1400); wr(4'd1, 16'd5); wr(4'd3, 16'd2);
    push_in(0); push_in(0);
    chk("R3 rx block done", op_status & 16'h0F00, 16'h0800);
    wr(4'd7, 16'h0F00);
    wr(4'd2, 16'd7); wr(4'd4, 16'd2);
    pop_out(10); pop_out(10);
    chk("R3 tx block done", op_status & 16'h0F00, 16'h0400);
    wr(4'd7, 16'h0F00);
    // R2 queue mode transmit target
    wr(4'd0, 16'h0000); wr(4'd4, 16'd9); wr(4'd2, 16'd1);
    pop_out(10);
    chk("R2 tx done", op_status & 16'h0F00, 16'h0400);
    wr(4'd7, 16'h0F00);
    wr(4'd1, 16'd0); wr(4'd2, 16'd0);

    // R8 disabled error ignored
    wr(4'd5, 16'h0000); push_in(16);
    chk("R8 disabled overrun", err_flags, 16'h0000);
    // R6 each error
    wr(4'd5, 16'h003C);
    push_in(16);
    chk("R6 rx overrun", err_flags, 16'h0004);
    @(negedge clk); in_level = 0; in_pop = 1; step();
    chk("R6 rx underrun", err_flags, 16'h0014);
    @(negedge clk); out_level = 16; out_push = 1; step();
    chk("R6 tx overrun", err_flags, 16'h0034);
    wr(4'd2, 16'd4);
    @(negedge clk); out_level = 0; out_shift_req = 1; step();
    chk("R6 tx underrun", err_flags, 16'h003C);
    wr(4'd8, 16'h0004);
    chk("R9 single bit clear", err_flags, 16'h0038);
    wr(4'd8, 16'h0038);
    chk("R9 full clear", err_flags, 16'h0000);
    wr(4'd2, 16'd0);
    @(negedge clk); out_level = 0; out_shift_req = 1; step();
    chk("R6 no underrun without remaining words", err_flags, 16'h0000);

    // R7 serial errors, R8 gating
    @(negedge clk); ser_clk_over = 1; step();
    chk("R8 serial disabled", ser_flags, 16'h0000);
    wr(4'd6, 16'h0003);
    @(negedge clk); ser_clk_over = 1; step();
    chk("R7 clock overrun", ser_flags, 16'h0002);
    @(negedge clk); ser_clk_under = 1; step();
    chk("R7 clock underrun", ser_flags, 16'h0003);
    wr(4'd9, 16'h0003);
    chk("R7 serial clear", ser_flags, 16'h0000);

    // R5 service flags
    push_in(7);
    chk("R5 rx service", op_status & 16'h0F00, 16'h0200);
    push_in(8);
    chk("R5 rx service only once", op_status & 16'h0F00, 16'h0200);
    pop_out(5);
    chk("R5 tx service", op_status & 16'h0F00, 16'h0300);
    wr(4'd7, 16'h0300);
    chk("R5 service clear", op_status & 16'h0F00, 16'h0000);

    // R9 set beats clear in the same cycle
    @(negedge clk);
    in_level = 16; in_push = 1; wr_en = 1; wr_sel = 4'd8; wr_data = 16'h0004;
    step();
    chk("R9 set wins", err_flags, 16'h0004);

    // R11 reset mid-run
    @(negedge clk); rst_n = 0; #1;
    chk("R11 err after reset", err_flags, 16'h0000);
    chk("R11 irq after reset", {15'b0, irq}, 16'h0000);
    @(negedge clk); rst_n = 1; in_level = 16; in_push = 1; step();
    chk("R11 enables cleared", err_flags, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule